// File: doc/BRIEF.md
# Masked Alarm Repeat Controller

This block holds four alarm registers, for seconds, minutes, hours and day of the month. A host writes and reads them one byte at a time through a register index. The block compares the stored alarm against a BCD time-of-day bus that a separate counter drives. Each time a one-second tick input rises, the block evaluates the comparison. On a match it emits a single-cycle interrupt pulse, provided the enable input is high.

Bit 7 of each alarm register is a "don't care" mask for that field. The pattern of the four mask bits selects the repeat rate: monthly, daily, hourly, once per minute, or every second. A write whose BCD value is out of range is discarded, and the register keeps its previous byte.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, all four alarm registers read 0x00 and `irq_pulse` is low.
- R2: `reg_idx` selects the register: 0 seconds, 1 minutes, 2 hours, 3 date. `reg_rdata` shows the selected register in the same cycle. The value read is the whole last accepted byte, including bit 7 and any bits above the value field.
- R3: A seconds or minutes write is accepted only when bits 6:0, read as BCD, have both digits at 9 or below and a value of 0 to 59. Bit 7 is stored but does not take part in the check.
- R4: An hours write is accepted only when bits 5:0, read as BCD, have a low digit at 9 or below and a value of 0 to 23.
- R5: A date write is accepted only when bits 5:0, read as BCD, have a low digit at 9 or below and a nonzero value.
- R6: A rejected write leaves the register byte unchanged, and so does a cycle with no write.
- R7: When all four mask bits (bit 7 of each register) are clear, a match needs seconds, minutes, hours and date all equal to the time bus.
- R8: When only the date mask is set, a match needs seconds, minutes and hours equal.
- R9: When only the date and hour masks are set, a match needs seconds and minutes equal.
- R10: When only the date, hour and minute masks are set, a match needs seconds equal.
- R11: Any other mask pattern, including all four set or the seconds mask alone, matches on every tick.
- R12: A match is evaluated only on a rising edge of `sec_tick`. `irq_pulse` goes high for exactly one clock, in the cycle after the clock edge that sees the tick rise. Holding the tick high produces no further pulse, even if the time later matches.
- R13: While `irq_en` is low at the tick edge, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_idx | input | 2 | Register index (0 sec, 1 min, 2 hour, 3 date) |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Byte of the selected register |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-second tick; its rising edge triggers evaluation |
| irq_en | input | 1 | Interrupt enable |
| irq_pulse | output | 1 | Single-cycle alarm interrupt |

## Verification
The pulse assertions assume that `sec_tick` is synchronous to `clk` and stays low for at least one clock between rises. They also assume that `irq_en` and the time bus are stable in the cycle the tick rises. The stimulus meets these assumptions by changing every input on the falling clock edge. The tick is held high for several cycles and then low for at least two before the next rise. The time bus and the enable are set up before the tick rises, except in one deliberate case where the time is changed while the tick is held high.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

   localparam int unsigned NUM_FIELDS = 4;
   localparam int unsigned FLD_SEC    = 0;
   localparam int unsigned FLD_MIN    = 1;
   localparam int unsigned FLD_HOUR   = 2;
   localparam int unsigned FLD_DATE   = 3;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned MASK_BIT   = 7;

   typedef enum logic [2:0] {
      RPT_MONTH  = 3'd0,
      RPT_DAY    = 3'd1,
      RPT_HOUR   = 3'd2,
      RPT_MINUTE = 3'd3,
      RPT_SECOND = 3'd4
   } rpt_mode_e;

   // value field width of each register
   function automatic int unsigned fld_width(input int unsigned f);
      return (f == FLD_SEC || f == FLD_MIN) ? 7 : 6;
   endfunction

   function automatic int unsigned fld_min(input int unsigned f);
      return (f == FLD_DATE) ? 1 : 0;
   endfunction

   function automatic int unsigned fld_max(input int unsigned f);
      case (f)
         FLD_SEC, FLD_MIN: return 59;
         FLD_HOUR:         return 23;
         default:          return 39;
      endcase
   endfunction

   function automatic logic bcd_digits_ok(input logic [7:0] v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

   function automatic logic [7:0] bcd_value(input logic [7:0] v);
      logic [7:0] hi;
      hi = {4'b0, v[7:4]};
      return (hi << 3) + (hi << 1) + {4'b0, v[3:0]};
   endfunction

endpackage

// File: rtl/tod_alarm_field.sv
module tod_alarm_field
   import tod_alarm_pkg::*;
#(
   parameter int unsigned VAL_W = 7,
   parameter int unsigned MIN_V = 0,
   parameter int unsigned MAX_V = 59,
   parameter logic [7:0]  RST_V = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic [7:0] q
);

   localparam logic [7:0] VAL_MASK = 8'((1 << VAL_W) - 1);

   if (VAL_W < 4 || VAL_W > 7) begin : g_bad_width
      $error("tod_alarm_field: VAL_W must lie in 4..7");
   end
   if (MAX_V < MIN_V || MAX_V > 79) begin : g_bad_range
      $error("tod_alarm_field: MIN_V/MAX_V inconsistent");
   end

   logic [7:0] low_b;
   logic [7:0] bin;
   logic       dig_ok;
   logic       lo_ok;
   logic       hi_ok;
   logic       accept;

   assign low_b  = wdata & VAL_MASK;
   assign bin    = bcd_value(low_b);
   assign dig_ok = bcd_digits_ok(low_b);
   assign hi_ok  = (bin <= 8'(MAX_V));

   if (MIN_V == 0) begin : g_no_floor
      assign lo_ok = 1'b1;
   end else begin : g_floor
      assign lo_ok = (bin >= 8'(MIN_V));
   end

   assign accept = dig_ok && lo_ok && hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= RST_V;
      else if (wr_en && accept) q <= wdata;
   end

   // R6: rejected write keeps the old byte
   a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !accept) |=> $stable(q))
      else $error("a_r6_reject_holds");

   // R6: no write, no change
   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q))
      else $error("a_r6_idle_holds");

   // R2: accepted write stores the full raw byte
   a_r2_raw_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && accept) |=> (q == $past(wdata)))
      else $error("a_r2_raw_stored");

endmodule

// File: rtl/tod_alarm_mode.sv
module tod_alarm_mode
   import tod_alarm_pkg::*;
(
   input  logic [NUM_FIELDS-1:0] mask,
   output rpt_mode_e             mode,
   output logic [NUM_FIELDS-1:0] need
);

   // mask bit order: [3] date, [2] hour, [1] minute, [0] second
   always_comb begin
      case (mask)
         4'b0000: begin mode = RPT_MONTH;  need = 4'b1111; end
         4'b1000: begin mode = RPT_DAY;    need = 4'b0111; end
         4'b1100: begin mode = RPT_HOUR;   need = 4'b0011; end
         4'b1110: begin mode = RPT_MINUTE; need = 4'b0001; end
         default: begin mode = RPT_SECOND; need = 4'b0000; end
      endcase
   end

endmodule

// File: rtl/tod_alarm_pulse.sv
module tod_alarm_pulse #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic [N-1:0] need,
   input  logic [N-1:0] eq,
   output logic         tick_edge,
   output logic         pulse
);

   logic tick_q;
   logic hit;

   assign hit       = &(~need | eq);
   assign tick_edge = tick & ~tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         tick_q <= tick;
         pulse  <= tick_edge & hit & en;
      end
   end

   a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse)
      else $error("a_r12_one_cycle");

   a_r12_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(tick))
      else $error("a_r12_after_tick");

   a_r13_gated: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(en))
      else $error("a_r13_gated");

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
   import tod_alarm_pkg::*;
#(
   parameter int unsigned IDX_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [IDX_W-1:0]      reg_idx,
   input  logic [BYTE_W-1:0]     reg_wdata,
   output logic [BYTE_W-1:0]     reg_rdata,
   input  logic [6:0]            tod_sec,
   input  logic [6:0]            tod_min,
   input  logic [5:0]            tod_hour,
   input  logic [5:0]            tod_date,
   input  logic                  sec_tick,
   input  logic                  irq_en,
   output logic                  irq_pulse
);

   if ((1 << IDX_W) != NUM_FIELDS) begin : g_bad_idx
      $error("tod_alarm_unit: IDX_W must address exactly NUM_FIELDS registers");
   end

   logic [BYTE_W-1:0]     fld_q   [NUM_FIELDS];
   logic [BYTE_W-1:0]     tod_pad [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] fld_eq;
   logic [NUM_FIELDS-1:0] fld_mask;
   logic [NUM_FIELDS-1:0] need;
   rpt_mode_e             rpt_mode;
   logic                  tick_edge;

   assign tod_pad[FLD_SEC]  = {1'b0,  tod_sec};
   assign tod_pad[FLD_MIN]  = {1'b0,  tod_min};
   assign tod_pad[FLD_HOUR] = {2'b00, tod_hour};
   assign tod_pad[FLD_DATE] = {2'b00, tod_date};

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      localparam int unsigned W = fld_width(g);
      localparam logic [BYTE_W-1:0] M = BYTE_W'((1 << W) - 1);

      tod_alarm_field #(
         .VAL_W (W),
         .MIN_V (fld_min(g)),
         .MAX_V (fld_max(g)),
         .RST_V (8'h00)
      ) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (reg_wr && (reg_idx == IDX_W'(g))),
         .wdata (reg_wdata),
         .q     (fld_q[g])
      );

      assign fld_eq[g]   = ((fld_q[g] & M) == tod_pad[g]);
      assign fld_mask[g] = fld_q[g][MASK_BIT];
   end

   assign reg_rdata = fld_q[reg_idx];

   tod_alarm_mode u_mode (
      .mask (fld_mask),
      .mode (rpt_mode),
      .need (need)
   );

   tod_alarm_pulse #(.N(NUM_FIELDS)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .en        (irq_en),
      .need      (need),
      .eq        (fld_eq),
      .tick_edge (tick_edge),
      .pulse     (irq_pulse)
   );

   // R11: per-second repeat fires on every enabled tick edge
   a_r11_every_second: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_edge && irq_en && rpt_mode == RPT_SECOND) |=> irq_pulse)
      else $error("a_r11_every_second");

   // R7: monthly repeat pulses only when the date field matched
   a_r7_month_needs_date: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse && $past(rpt_mode) == RPT_MONTH) |-> $past(fld_eq[FLD_DATE]))
      else $error("a_r7_month_needs_date");

endmodule

// File: tb/tod_alarm_unit_bench.sv
module tod_alarm_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_idx = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [6:0] tod_sec = 7'h00;
   logic [6:0] tod_min = 7'h00;
   logic [5:0] tod_hour = 6'h00;
   logic [5:0] tod_date = 6'h01;
   logic       sec_tick = 1'b0;
   logic       irq_en = 1'b0;
   logic       irq_pulse;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] shadow [4];

   typedef struct {
      int    due;
      bit    exp;
      string tag;
   } exp_t;
   exp_t sbq[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tod_alarm_unit u_tod_alarm_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
      .tod_date(tod_date), .sec_tick(sec_tick), .irq_en(irq_en),
      .irq_pulse(irq_pulse)
   );

   // acceptance rule from R3/R4/R5
   function automatic bit will_accept(input int idx, input logic [7:0] d);
      int lo, hi, v;
      lo = int'(d[3:0]);
      hi = (idx < 2) ? int'(d[6:4]) : int'(d[5:4]);
      v  = hi * 10 + lo;
      if (lo > 9) return 0;
      case (idx)
         0, 1:    return v <= 59;
         2:       return v <= 23;
         default: return v != 0;
      endcase
   endfunction

   // repeat rule from R7..R11
   function automatic bit fire_model();
      bit ms, mm, mh, md, es, em, eh, ed;
      ms = shadow[0][7]; mm = shadow[1][7]; mh = shadow[2][7]; md = shadow[3][7];
      es = (shadow[0][6:0] == tod_sec);
      em = (shadow[1][6:0] == tod_min);
      eh = (shadow[2][5:0] == tod_hour);
      ed = (shadow[3][5:0] == tod_date);
      if (!md && !mh && !mm && !ms) return es && em && eh && ed;
      if (md && !mh && !mm && !ms)  return es && em && eh;
      if (md && mh && !mm && !ms)   return es && em;
      if (md && mh && mm && !ms)    return es;
      return 1'b1;
   endfunction

   // monitor: pops expected pulse states and flags any stray pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t it;
            it = sbq.pop_front();
            checks++;
            if (irq_pulse !== it.exp) begin
               errors++;
               $display("FAIL %s: irq_pulse actual %b expected %b", it.tag, irq_pulse, it.exp);
            end
         end else if (irq_pulse !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R12 stray pulse: irq_pulse actual %b expected 0 (cycle %0d)", irq_pulse, cyc);
         end
      end
   end

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      reg_idx = 2'(idx); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (will_accept(idx, d)) shadow[idx] = d;
   endtask

   task automatic rd_chk(input int idx, input string tag);
      @(negedge clk);
      reg_idx = 2'(idx);
      #1;
      checks++;
      if (reg_rdata !== shadow[idx]) begin
         errors++;
         $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, reg_rdata, shadow[idx]);
      end
   endtask

   task automatic set_tod(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d);
      @(negedge clk);
      tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
   endtask

   // driver: raise tick, push expected state of the pulse
   task automatic do_tick(input string tag, input int hold);
      @(negedge clk);
      sec_tick = 1'b1;
      sbq.push_back('{cyc + 1, irq_en & fire_model(), tag});
      repeat (hold) @(negedge clk);
      sec_tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL R12 watchdog: run actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 4; i++) rd_chk(i, "R1 reset value");
      checks++;
      if (irq_pulse !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset pulse: actual %b expected 0", irq_pulse);
      end

      // R3 / R6 seconds and minutes range
      wr(0, 8'h59); rd_chk(0, "R3 sec 59 accepted");
      wr(0, 8'h60); rd_chk(0, "R6 sec 60 rejected");
      wr(0, 8'h5A); rd_chk(0, "R3 sec bad digit rejected");
      wr(1, 8'h3A); rd_chk(1, "R3 min bad digit rejected");
      wr(1, 8'h34); rd_chk(1, "R3 min 34 accepted");
      // R4 hours
      wr(2, 8'h24); rd_chk(2, "R4 hour 24 rejected");
      wr(2, 8'h45); rd_chk(2, "R2 hour raw byte kept");
      wr(2, 8'h12); rd_chk(2, "R4 hour 12 accepted");
      // R5 date
      wr(3, 8'h00); rd_chk(3, "R5 date zero rejected");
      wr(3, 8'h80); rd_chk(3, "R5 masked zero rejected");
      wr(3, 8'h1A); rd_chk(3, "R5 date bad digit rejected");
      wr(3, 8'h39); rd_chk(3, "R5 date 39 accepted");
      wr(3, 8'h15); rd_chk(3, "R5 date 15 accepted");
      wr(0, 8'h56); rd_chk(0, "R2 sec readback");

      irq_en = 1'b1;
      // R7 monthly
      set_tod(7'h56, 7'h34, 6'h12, 6'h15); do_tick("R7 full match fires", 3);
      set_tod(7'h56, 7'h34, 6'h12, 6'h16); do_tick("R7 date differs no fire", 3);
      // R8 daily
      wr(3, 8'h95); rd_chk(3, "R2 mask bit readback");
      do_tick("R8 date ignored fires", 3);
      set_tod(7'h56, 7'h34, 6'h13, 6'h16); do_tick("R8 hour differs no fire", 3);
      // R9 hourly
      wr(2, 8'h92); do_tick("R9 hour ignored fires", 3);
      set_tod(7'h56, 7'h35, 6'h13, 6'h16); do_tick("R9 minute differs no fire", 3);
      // R10 per minute
      wr(1, 8'hB4); do_tick("R10 minute ignored fires", 3);
      set_tod(7'h57, 7'h35, 6'h13, 6'h16); do_tick("R10 second differs no fire", 3);
      // R11 all masks, then seconds mask alone
      wr(0, 8'hD6); do_tick("R11 all masks fires", 3);
      wr(3, 8'h15); wr(2, 8'h12); wr(1, 8'h34);
      do_tick("R11 seconds mask alone fires", 3);
      // R13 enable low
      irq_en = 1'b0;
      do_tick("R13 disabled no fire", 3);
      irq_en = 1'b1;
      // R12 long hold yields one pulse (monitor flags extras)
      do_tick("R12 held tick single pulse", 8);
      // R12 no re-evaluation while tick stays high
      wr(0, 8'h56);
      set_tod(7'h57, 7'h34, 6'h12, 6'h15);
      @(negedge clk);
      sec_tick = 1'b1;
      sbq.push_back('{cyc + 1, 1'b0, "R12 mismatch at edge no fire"});
      repeat (2) @(negedge clk);
      tod_sec = 7'h56;
      sbq.push_back('{cyc + 2, 1'b0, "R12 match while held no fire"});
      repeat (4) @(negedge clk);
      sec_tick = 1'b0;
      repeat (2) @(negedge clk);
      do_tick("R7 match after fresh edge fires", 3);

      repeat (4) @(negedge clk);
      if (sbq.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R12 scoreboard: pending actual %0d expected 0", sbq.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule